// File: doc/BRIEF.md
# ECC Error Capture Log

This block sits behind a memory controller's ECC checker and keeps a single 32-bit log word that describes one read error. On every cycle it may receive a correctable or an uncorrectable error report, an 8-bit syndrome, a poison indication, and the bank, rank and chunk of the read transaction. It raises a status flag for each class of error. It captures the address and syndrome of one error and holds them for software.

The capture follows a fixed priority. When no flag is set, the first error is logged. A logged correctable error is protected against later correctable errors, but a later uncorrectable error replaces it. Once an uncorrectable error has been logged, nothing replaces it. Software releases the log by pulsing the per-flag clear inputs. These inputs are driven by the error-status register elsewhere in the chip. The reset input is the power-good reset only, so a warm reset leaves the log intact. A one-cycle pulse marks each cycle in which a new capture appears in the word.

Top module: `ecc_err_log`

## Requirements
- R1: The log word holds, from bit 31 down: bank (3 bits, 31:29), rank (2 bits, 28:27), chunk (3 bits, 26:24), syndrome (8 bits, 23:16), zeros in 15:2, the uncorrectable flag in bit 1 and the correctable flag in bit 0.
- R2: When neither flag is set, a correctable error sets bit 0 and captures its bank, rank, chunk and syndrome. These values show in the word one clock later.
- R3: While bit 0 is set and bit 1 is clear, a further correctable error leaves bits 31:16 unchanged.
- R4: While bit 1 is clear, an uncorrectable error captures its bank, rank, chunk and syndrome and sets bit 1. This happens even if a correctable error is already logged.
- R5: While bit 1 is set, bits 31:16 are frozen against every new error. A correctable error in that state still sets bit 0.
- R6: An error reported with the poison input high logs syndrome 0xFF in place of its syndrome input. Poison with no error report has no effect.
- R7: clr_ce_i clears bit 0 and clr_ue_i clears bit 1. Bits 31:16 keep their values, and a cleared log accepts the next capture.
- R8: A correctable and an uncorrectable error in the same cycle are logged as the uncorrectable one, and both flags become set.
- R9: An error and a clear of its own flag in the same cycle act as if the clear came first: the error is captured and its flag stays set.
- R10: cap_o is high for exactly the cycles in which a newly captured error first appears in the log word, and low otherwise.
- R11: An asynchronous reset (rst_ni low) sets the log word and cap_o to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-good reset |
| ce_i | input | 1 | Correctable error on this read |
| ue_i | input | 1 | Uncorrectable error on this read |
| poison_i | input | 1 | Read data was poisoned |
| synd_i | input | 8 | Syndrome from the ECC checker |
| bank_i | input | 3 | Bank of the read |
| rank_i | input | 2 | Rank of the read |
| chunk_i | input | 3 | Chunk number of the read |
| clr_ce_i | input | 1 | Clear correctable flag |
| clr_ue_i | input | 1 | Clear uncorrectable flag |
| log_o | output | 32 | Log word |
| cap_o | output | 1 | One-cycle pulse when a capture appears |

## Verification
The bench goes after the priority edges. It sends a second correctable error into a held correctable log; a design that ignored the lock would show the new address. It sends a correctable error after an uncorrectable one, and an uncorrectable one after another, which would overwrite the frozen fields. It raises both error classes in one cycle, where a design that picked the correctable one would log the wrong syndrome. It also pulses a clear and an error together; a design that decided the lock before applying the clear would drop that capture. Further cases show whether clearing a flag wipes the retained fields, whether poison alone sneaks into the log, and whether a poisoned error keeps its raw syndrome.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int unsigned BANK_W  = 3;
  localparam int unsigned RANK_W  = 2;
  localparam int unsigned CHUNK_W = 3;
  localparam int unsigned SYND_W  = 8;
  localparam int unsigned LOG_W   = 32;
  localparam int unsigned FLAG_N  = 2;
  localparam int unsigned FIELD_W = BANK_W + RANK_W + CHUNK_W + SYND_W;
  localparam int unsigned RSVD_W  = LOG_W - FIELD_W - FLAG_N;
  localparam logic [SYND_W-1:0] POISON_SYND = '1;

  // flag index in log word
  localparam int unsigned F_CE = 0;
  localparam int unsigned F_UE = 1;

  typedef struct packed {
    logic [BANK_W-1:0]  bank;
    logic [RANK_W-1:0]  rank;
    logic [CHUNK_W-1:0] chunk;
    logic [SYND_W-1:0]  synd;
  } err_rec_t;
endpackage

// File: rtl/ecc_log_flag.sv
module ecc_log_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o,
  output logic held_o
);
  logic flag_q;

  // clear applies before a same-cycle set
  assign held_o = flag_q & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i | held_o;
  end

  assign flag_o = flag_q;

  // R7
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/ecc_log_fields.sv
module ecc_log_fields
  import ecc_log_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cap_i,
  input  logic     poison_i,
  input  err_rec_t rec_i,
  output err_rec_t rec_o,
  output logic     cap_o
);
  err_rec_t rec_q, rec_d;
  logic     cap_q;

  always_comb begin
    rec_d = rec_i;
    if (poison_i) rec_d.synd = POISON_SYND;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q <= '0;
      cap_q <= 1'b0;
    end else begin
      cap_q <= cap_i;
      if (cap_i) rec_q <= rec_d;
    end
  end

  assign rec_o = rec_q;
  assign cap_o = cap_q;

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(rec_o));
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_i,
  input  logic               ue_i,
  input  logic               poison_i,
  input  logic [SYND_W-1:0]  synd_i,
  input  logic [BANK_W-1:0]  bank_i,
  input  logic [RANK_W-1:0]  rank_i,
  input  logic [CHUNK_W-1:0] chunk_i,
  input  logic               clr_ce_i,
  input  logic               clr_ue_i,
  output logic [LOG_W-1:0]   log_o,
  output logic               cap_o
);
  logic [FLAG_N-1:0] set_v, clr_v, flag_v, held_v;
  logic              cap_go;
  err_rec_t          rec_in, rec_out;

  assign set_v[F_CE] = ce_i;
  assign set_v[F_UE] = ue_i;
  assign clr_v[F_CE] = clr_ce_i;
  assign clr_v[F_UE] = clr_ue_i;

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    ecc_log_flag i_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .flag_o (flag_v[g]),
      .held_o (held_v[g])
    );
  end

  // uncorrectable lock blocks all; correctable lock blocks only correctable
  assign cap_go = (ue_i & ~held_v[F_UE]) |
                  (ce_i & ~held_v[F_CE] & ~held_v[F_UE]);

  assign rec_in = '{bank: bank_i, rank: rank_i, chunk: chunk_i, synd: synd_i};

  ecc_log_fields i_fields (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap_go),
    .poison_i (poison_i),
    .rec_i    (rec_in),
    .rec_o    (rec_out),
    .cap_o    (cap_o)
  );

  assign log_o = {rec_out, {RSVD_W{1'b0}}, flag_v};

  // R2
  ce_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |=> log_o[F_CE]);
  // R4
  ue_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ue_i |=> log_o[F_UE]);
  // R3
  ce_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (log_o[F_CE] && !clr_ce_i && !ue_i) |=> $stable(log_o[LOG_W-1:LOG_W-FIELD_W]));
  // R5
  ue_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (log_o[F_UE] && !clr_ue_i) |=> $stable(log_o[LOG_W-1:LOG_W-FIELD_W]));
  // R6
  poison_synd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_o && $past(poison_i)) |-> (log_o[LOG_W-BANK_W-RANK_W-CHUNK_W-1 -: SYND_W] == POISON_SYND));
  // R10
  cap_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> $past(ce_i || ue_i));
  // R9
  ue_reclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ue_i && clr_ue_i) |=> (cap_o && log_o[F_UE]));
endmodule

// File: tb/test_ecc_err_log.sv
module test_ecc_err_log;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 0, ue = 0, po = 0, clr_ce = 0, clr_ue = 0;
  logic [7:0]  synd = '0;
  logic [2:0]  bank = '0, chunk = '0;
  logic [1:0]  rank = '0;
  logic [31:0] log_w;
  logic        cap;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  ecc_err_log i_ecc_err_log (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .ue_i(ue), .poison_i(po),
    .synd_i(synd), .bank_i(bank), .rank_i(rank), .chunk_i(chunk),
    .clr_ce_i(clr_ce), .clr_ue_i(clr_ue), .log_o(log_w), .cap_o(cap)
  );

  // {ce,ue,poison,synd,bank,rank,chunk,clr_ce,clr_ue, exp_word, exp_cap}
  localparam int NV = 18;
  localparam logic [53:0] TBL [NV] = '{
    {1'b1,1'b0,1'b0,8'h12,3'd5,2'd2,3'd3,1'b0,1'b0,32'hB3120001,1'b1},
    {1'b1,1'b0,1'b0,8'h34,3'd1,2'd1,3'd1,1'b0,1'b0,32'hB3120001,1'b0},
    {1'b0,1'b0,1'b0,8'h00,3'd0,2'd0,3'd0,1'b0,1'b0,32'hB3120001,1'b0},
    {1'b0,1'b1,1'b0,8'h56,3'd2,2'd3,3'd7,1'b0,1'b0,32'h5F560003,1'b1},
    {1'b0,1'b1,1'b0,8'h78,3'd7,2'd0,3'd0,1'b0,1'b0,32'h5F560003,1'b0},
    {1'b1,1'b0,1'b0,8'h9A,3'd0,2'd0,3'd0,1'b0,1'b0,32'h5F560003,1'b0},
    {1'b0,1'b0,1'b0,8'h00,3'd0,2'd0,3'd0,1'b1,1'b0,32'h5F560002,1'b0},
    {1'b1,1'b0,1'b0,8'h11,3'd3,2'd1,3'd2,1'b0,1'b0,32'h5F560003,1'b0},
    {1'b0,1'b0,1'b0,8'h00,3'd0,2'd0,3'd0,1'b1,1'b1,32'h5F560000,1'b0},
    {1'b1,1'b1,1'b0,8'h22,3'd4,2'd0,3'd5,1'b0,1'b0,32'h85220003,1'b1},
    {1'b1,1'b0,1'b0,8'h33,3'd1,2'd0,3'd0,1'b1,1'b1,32'h20330001,1'b1},
    {1'b1,1'b0,1'b0,8'h44,3'd6,2'd3,3'd6,1'b1,1'b0,32'hDE440001,1'b1},
    {1'b0,1'b1,1'b1,8'h05,3'd0,2'd0,3'd1,1'b0,1'b0,32'h01FF0003,1'b1},
    {1'b0,1'b0,1'b0,8'h00,3'd0,2'd0,3'd0,1'b1,1'b1,32'h01FF0000,1'b0},
    {1'b0,1'b0,1'b1,8'h66,3'd7,2'd0,3'd0,1'b0,1'b0,32'h01FF0000,1'b0},
    {1'b1,1'b0,1'b1,8'h07,3'd2,2'd1,3'd4,1'b0,1'b0,32'h4CFF0001,1'b1},
    {1'b0,1'b0,1'b0,8'h00,3'd0,2'd0,3'd0,1'b0,1'b1,32'h4CFF0001,1'b0},
    {1'b1,1'b1,1'b0,8'h99,3'd3,2'd2,3'd1,1'b0,1'b0,32'h71990003,1'b1}
  };

  function automatic string vec_req(int i);
    case (i)
      0:  return "R2/R1";
      1:  return "R3";
      2:  return "R10";
      3:  return "R4";
      4:  return "R5";
      5:  return "R5";
      6:  return "R7";
      7:  return "R5";
      8:  return "R7";
      9:  return "R8";
      10: return "R9";
      11: return "R9";
      12: return "R6";
      13: return "R7";
      14: return "R6";
      15: return "R6";
      16: return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] w_exp, logic c_exp);
    n_chk++;
    if (log_w !== w_exp || cap !== c_exp) begin
      n_fail++;
      $display("FAIL %s: log=%h cap=%b expected log=%h cap=%b", req, log_w, cap, w_exp, c_exp);
    end
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #35;
    check("R11", 32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      ce     = TBL[i][53];
      ue     = TBL[i][52];
      po     = TBL[i][51];
      synd   = TBL[i][50:43];
      bank   = TBL[i][42:40];
      rank   = TBL[i][39:38];
      chunk  = TBL[i][37:35];
      clr_ce = TBL[i][34];
      clr_ue = TBL[i][33];
      @(negedge clk);
      check(vec_req(i), TBL[i][32:1], TBL[i][0]);
    end

    // R10: pulse lasts one cycle after a capture
    {ce, ue, po, clr_ce, clr_ue} = '0;
    @(negedge clk);
    check("R10", 32'h71990003, 1'b0);

    // R11: asynchronous reset mid-cycle clears everything
    #3 rst_n = 1'b0;
    #2 check("R11", 32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: after reset the log accepts a fresh correctable error
    ce = 1'b1; synd = 8'hA5; bank = 3'd7; rank = 2'd3; chunk = 3'd7;
    @(negedge clk);
    check("R2", 32'hFFA50001, 1'b1);
    ce = 1'b0;
    @(negedge clk);
    check("R10", 32'hFFA50001, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule